// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is the datapath operator of a small processor. It is purely combinational. It takes two operands of `WIDTH` bits, a carry-in, a 4-bit function code and two serial fill bits. From these it produces one result word, a carry-out and a signed-overflow flag. The upper two function bits pick one of four groups: arithmetic, bitwise logic, shift right, or shift left. Within the arithmetic and logic groups, the lower two bits pick the operation.

All arithmetic comes from one ripple-carry adder that computes `A + Y + cin`. Each bit of `Y` is a preconditioned copy of `B`: either `B`, `NOT B`, all zeros or all ones. The carry-in then separates add from add-with-carry, subtract from add-with-complement, transfer from increment, and decrement from transfer. This gives seven distinct results. The shift paths move `A` by one position, and the vacated bit is taken from a serial input. The function code is the only steering input, and the unit holds no state.

Top module: `alsu_unit`

## Requirements
- R1: With sel_i = 4'b0000, res_o equals (a_i + b_i + cin_i) modulo 2^WIDTH, and cout_o is bit WIDTH of that full sum.
- R2: With sel_i = 4'b0001, res_o equals (a_i + ~b_i + cin_i) modulo 2^WIDTH. With cin_i = 1 this is a_i - b_i, and cout_o = 1 means that no borrow occurred.
- R3: With sel_i = 4'b0010, res_o equals a_i + cin_i, which is a transfer or an increment. cout_o = 1 exactly when a_i is all ones and cin_i = 1.
- R4: With sel_i = 4'b0011, res_o equals a_i plus all ones plus cin_i. With cin_i = 0 this is a decrement, and cout_o = 0 only when a_i = 0. With cin_i = 1 this is a transfer with cout_o = 1.
- R5: In the arithmetic group (sel_i[3:2] = 2'b00), ovf_o is 1 exactly when both adder operands a_i and Y have the same sign bit and the sign bit of res_o differs from it. This is the same as the carry into the top bit XOR the carry out of it.
- R6: With sel_i[3:2] = 2'b01, sel_i[1:0] selects the bitwise function: 00 gives a_i XOR b_i, 01 gives a_i OR b_i, 10 gives a_i AND b_i, and 11 gives NOT a_i.
- R7: With sel_i[3:2] = 2'b10, res_o[i] = a_i[i+1] for i < WIDTH-1, and res_o[WIDTH-1] = sr_fill_i. b_i and sel_i[1:0] have no effect.
- R8: With sel_i[3:2] = 2'b11, res_o[i] = a_i[i-1] for i > 0, and res_o[0] = sl_fill_i. b_i and sel_i[1:0] have no effect.
- R9: Whenever sel_i[3:2] is not 2'b00, cout_o and ovf_o are 0 and cin_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand; the source of the shifts |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Adder carry-in |
| sel_i | input | 4 | Function code: [3:2] selects the group, [1:0] selects the operation |
| sr_fill_i | input | 1 | Bit fed into the top position on a right shift |
| sl_fill_i | input | 1 | Bit fed into the bottom position on a left shift |
| res_o | output | WIDTH | Result word |
| cout_o | output | 1 | Adder carry-out; 0 outside the arithmetic group |
| ovf_o | output | 1 | Signed overflow; 0 outside the arithmetic group |

## Verification
The bench aims at the carry boundaries. An all-ones operand with carry-in exposes a broken ripple or a carry-out taken from the wrong bit. Decrementing zero and subtracting a larger value from a smaller one expose an inverted borrow sense. The signed limits 0x7F+1, 0x80+0x80 and 0x80-1 expose an overflow computed from the wrong carry pair, which would flag ordinary carries or miss sign reversals. Each shift is driven with both fill values, and logic and shift codes are repeated with the carry-in flipped. A design that takes the fill from the wrong end, swaps directions, or leaks the carry or flags into non-arithmetic results therefore produces visible mismatches.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_SHR   = 2'b10,
    GRP_SHL   = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NB   = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;

  typedef enum logic [1:0] {
    LOP_XOR = 2'b00,
    LOP_OR  = 2'b01,
    LOP_AND = 2'b10,
    LOP_NOT = 2'b11
  } lop_e;

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] y_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] y;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    // per-bit operand preconditioning
    always_comb begin
      unique case (ysel_e'(op_i))
        YSEL_B:    y[i] = b_i[i];
        YSEL_NB:   y[i] = ~b_i[i];
        YSEL_ZERO: y[i] = 1'b0;
        default:   y[i] = 1'b1;
      endcase
    end
    // full adder
    assign sum_o[i]   = a_i[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & y[i]) | ((a_i[i] ^ y[i]) & carry[i]);
  end

  assign y_o    = y;
  assign cout_o = carry[WIDTH];
  assign ovf_o  = carry[WIDTH] ^ carry[MSB];

  // ripple chain against a behavioural sum
  always_comb begin
    a_r1_ripple_sum: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, y} + {{WIDTH{1'b0}}, cin_i}))
      else $error("ripple sum mismatch");
    a_r5_ovf_sign_rule: assert (ovf_o == ((a_i[MSB] == y[MSB]) && (sum_o[MSB] != a_i[MSB])))
      else $error("overflow disagrees with sign rule");
    if (ysel_e'(op_i) == YSEL_ZERO) begin
      a_r3_zero_operand: assert (y == '0) else $error("zero operand not zero");
    end
  end

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] res_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (lop_e'(op_i))
        LOP_XOR: res_o[i] = a_i[i] ^ b_i[i];
        LOP_OR:  res_o[i] = a_i[i] | b_i[i];
        LOP_AND: res_o[i] = a_i[i] & b_i[i];
        default: res_o[i] = ~a_i[i];
      endcase
    end
  end

  always_comb begin
    if (lop_e'(op_i) == LOP_NOT) begin
      a_r6_not_ignores_b: assert ((res_o & a_i) == '0 && (res_o | a_i) == '1)
        else $error("complement path wrong");
    end
    if (lop_e'(op_i) == LOP_AND) begin
      a_r6_and_subset: assert ((res_o & ~a_i) == '0 && (res_o & ~b_i) == '0)
        else $error("and path sets a bit outside operands");
    end
  end

endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             sr_fill_i,
  input  logic             sl_fill_i,
  output logic [WIDTH-1:0] shr_o,
  output logic [WIDTH-1:0] shl_o
);

  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == MSB) begin : g_top
      assign shr_o[i] = sr_fill_i;
    end else begin : g_mid_r
      assign shr_o[i] = a_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl_o[i] = sl_fill_i;
    end else begin : g_mid_l
      assign shl_o[i] = a_i[i-1];
    end
  end

  always_comb begin
    a_r7_shr_arith: assert (shr_o == ((a_i >> 1) | ({{MSB{1'b0}}, sr_fill_i} << MSB)))
      else $error("right shift wrong");
    a_r8_shl_arith: assert (shl_o == ((a_i << 1) | {{MSB{1'b0}}, sl_fill_i}))
      else $error("left shift wrong");
  end

endmodule

// File: rtl/alsu_unit.sv
module alsu_unit
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [3:0]       sel_i,
  input  logic             sr_fill_i,
  input  logic             sl_fill_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  grp_e             grp;
  logic [WIDTH-1:0] arith_res, arith_y, logic_res, shr_res, shl_res;
  logic             arith_cout, arith_ovf;

  assign grp = grp_e'(sel_i[3:2]);

  alsu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .op_i  (sel_i[1:0]),
    .sum_o (arith_res),
    .y_o   (arith_y),
    .cout_o(arith_cout),
    .ovf_o (arith_ovf)
  );

  alsu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (sel_i[1:0]),
    .res_o(logic_res)
  );

  alsu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i      (a_i),
    .sr_fill_i(sr_fill_i),
    .sl_fill_i(sl_fill_i),
    .shr_o    (shr_res),
    .shl_o    (shl_res)
  );

  // group select; flags only leave in the arithmetic group
  always_comb begin
    unique case (grp)
      GRP_ARITH: res_o = arith_res;
      GRP_LOGIC: res_o = logic_res;
      GRP_SHR:   res_o = shr_res;
      default:   res_o = shl_res;
    endcase
  end

  assign cout_o = (grp == GRP_ARITH) & arith_cout;
  assign ovf_o  = (grp == GRP_ARITH) & arith_ovf;

  always_comb begin
    if (grp == GRP_ARITH) begin
      a_r5_top_ovf: assert (!ovf_o || (a_i[MSB] == arith_y[MSB] && res_o[MSB] != a_i[MSB]))
        else $error("overflow raised without sign reversal");
    end else begin
      a_r9_flags_quiet: assert (!cout_o && !ovf_o) else $error("flags leak outside arithmetic");
    end
    if (grp == GRP_SHR) begin
      a_r7_top_fill: assert (res_o[MSB] == sr_fill_i && res_o[MSB-1:0] == a_i[MSB:1])
        else $error("right shift output wrong");
    end
    if (grp == GRP_SHL) begin
      a_r8_bot_fill: assert (res_o[0] == sl_fill_i && res_o[MSB:1] == a_i[MSB-1:0])
        else $error("left shift output wrong");
    end
  end

endmodule

// File: tb/sim_alsu_unit.sv
`timescale 1ns/1ps
module sim_alsu_unit;

  localparam int W = 8;

  typedef struct {
    logic [W-1:0] res;
    logic         cout;
    logic         ovf;
    string        tag;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [3:0]   sel;
    logic         cin;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0, sr = 1'b0, sl = 1'b0;
  logic [3:0]   sel = '0;
  logic [W-1:0] res;
  logic         cout, ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  alsu_unit #(.WIDTH(W)) u0 (
    .a_i(a), .b_i(b), .cin_i(cin), .sel_i(sel),
    .sr_fill_i(sr), .sl_fill_i(sl),
    .res_o(res), .cout_o(cout), .ovf_o(ovf)
  );

  function automatic item_t model(logic [W-1:0] xa, logic [W-1:0] xb, logic xc,
                                  logic [3:0] xs, logic xr, logic xl, string tag);
    item_t it;
    logic [W-1:0] y;
    logic [W:0]   full;
    it.a = xa; it.b = xb; it.sel = xs; it.cin = xc; it.tag = tag;
    it.cout = 1'b0; it.ovf = 1'b0;
    case (xs[3:2])
      2'b00: begin
        case (xs[1:0])
          2'b00: y = xb;
          2'b01: y = ~xb;
          2'b10: y = '0;
          default: y = '1;
        endcase
        full   = {1'b0, xa} + {1'b0, y} + (W+1)'(xc);
        it.res = full[W-1:0];
        it.cout = full[W];
        it.ovf = (xa[W-1] == y[W-1]) && (full[W-1] != xa[W-1]);
      end
      2'b01: begin
        case (xs[1:0])
          2'b00: it.res = xa ^ xb;
          2'b01: it.res = xa | xb;
          2'b10: it.res = xa & xb;
          default: it.res = ~xa;
        endcase
      end
      2'b10: it.res = {xr, xa[W-1:1]};
      default: it.res = {xa[W-2:0], xl};
    endcase
    return it;
  endfunction

  task automatic drive(logic [W-1:0] xa, logic [W-1:0] xb, logic xc,
                       logic [3:0] xs, logic xr, logic xl, string tag);
    @(negedge clk);
    a = xa; b = xb; cin = xc; sel = xs; sr = xr; sl = xl;
    sb_q.push_back(model(xa, xb, xc, xs, xr, xl, tag));
  endtask

  // monitor: compare one queued item per cycle, after the inputs settle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if (res !== e.res || cout !== e.cout || ovf !== e.ovf) begin
          n_bad++;
          $display("FAIL %s a=%h b=%h cin=%b sel=%b: got res=%h c=%b v=%b exp res=%h c=%b v=%b",
                   e.tag, e.a, e.b, e.cin, e.sel, res, cout, ovf, e.res, e.cout, e.ovf);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running after %0d cycles exp finished", 50000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    n_cmp++; // reset-time state, all inputs zero: R1
    if (res !== '0 || cout !== 1'b0 || ovf !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got res=%h c=%b v=%b exp res=00 c=0 v=0", res, cout, ovf);
    end
    rst_n = 1'b1;

    drive(8'h3C, 8'h05, 0, 4'b0000, 0, 0, "R1");
    drive(8'h3C, 8'h05, 1, 4'b0000, 0, 0, "R1");
    drive(8'hFF, 8'h01, 0, 4'b0000, 0, 0, "R1");
    drive(8'h05, 8'h03, 1, 4'b0001, 0, 0, "R2");
    drive(8'h03, 8'h05, 1, 4'b0001, 0, 0, "R2");
    drive(8'h03, 8'h05, 0, 4'b0001, 0, 0, "R2");
    drive(8'hFF, 8'h5A, 1, 4'b0010, 0, 0, "R3");
    drive(8'h12, 8'h5A, 0, 4'b0010, 0, 0, "R3");
    drive(8'h00, 8'hA5, 0, 4'b0011, 0, 0, "R4");
    drive(8'h10, 8'hA5, 0, 4'b0011, 0, 0, "R4");
    drive(8'h10, 8'hA5, 1, 4'b0011, 0, 0, "R4");
    drive(8'h7F, 8'h01, 0, 4'b0000, 0, 0, "R5");
    drive(8'h80, 8'h80, 0, 4'b0000, 0, 0, "R5");
    drive(8'h80, 8'h01, 1, 4'b0001, 0, 0, "R5");
    drive(8'h7F, 8'h00, 1, 4'b0010, 0, 0, "R5");
    drive(8'h80, 8'h00, 0, 4'b0011, 0, 0, "R5");
    for (int op = 0; op < 4; op++) begin
      drive(8'hC3, 8'h5A, 0, {2'b01, 2'(op)}, 0, 0, "R6");
      drive(8'hC3, 8'h5A, 1, {2'b01, 2'(op)}, 0, 0, "R9");
    end
    drive(8'hB4, 8'h00, 0, 4'b1000, 0, 0, "R7");
    drive(8'hB4, 8'hFF, 1, 4'b1011, 1, 0, "R7");
    drive(8'h01, 8'h33, 0, 4'b1001, 1, 1, "R9");
    drive(8'hB4, 8'h00, 0, 4'b1100, 0, 0, "R8");
    drive(8'hB4, 8'hFF, 1, 4'b1110, 0, 1, "R8");
    drive(8'h80, 8'h33, 1, 4'b1111, 1, 0, "R9");
    for (int k = 0; k < 600; k++) begin
      logic [3:0] s;
      s = 4'($urandom);
      drive(8'($urandom), 8'($urandom), 1'($urandom), s, 1'($urandom), 1'($urandom),
            s[3:2] == 2'b00 ? "R1" : s[3:2] == 2'b01 ? "R6" : s[3:2] == 2'b10 ? "R7" : "R8");
    end
    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule